// File: doc/BRIEF.md
# Fan Speed and Duty Register Target on I2C

This block lets a host on a two-wire I2C bus switch a cooling fan on or off, set its drive strength, and read back how fast it turns. It answers at one fixed 7-bit address (0x74 by default, set by a parameter). A host writes a register pointer byte and then data bytes, or sets the pointer and issues a repeated START to read. The pointer advances by one after every data byte moved in either direction.

Register writes and reads at the same pointer reach different storage. Pointer 0 holds the control byte in both directions. Pointer 1 takes a drive duty in percent on write, but returns the measured revolutions per second on read. The block makes a PWM wave from a step counter with 100 steps. It counts rising tachometer edges over fixed windows (one second at the default 20 MHz clock). SDA is driven only low, through an output enable. SCL is only an input, so the target never stretches the clock.

Top module: `fan_i2c_target`

## Requirements
- R1: A START followed by address byte 0x74 (7-bit address in bits 7:1, R/W in bit 0) is acknowledged by driving SDA low during the ninth clock. Any other address is not acknowledged, and the bytes that follow it until the next START are ignored.
- R2: In a write transaction, the first byte after the address loads the register pointer. A data byte written at pointer 0 is stored as the whole control byte, and reading pointer 0 returns that byte unchanged.
- R3: Bit 7 of the control byte enables the fan. While it is 0, the PWM output stays low whatever the duty.
- R4: A data byte written at pointer 1 sets the duty in percent. The PWM output repeats every 100 steps of PWM_DIV clocks each. It is high for exactly duty steps of every period while the fan is enabled.
- R5: A duty value above 100 written at pointer 1 is stored as 100, which holds the PWM output high for the full period.
- R6: Reading pointer 1 returns the number of synchronized rising tachometer edges in the most recently completed window of WINDOW_CYCLES clocks. The count saturates at 255.
- R7: Reading any pointer other than 0 or 1 returns 0x00. Writing any such pointer changes neither the control byte nor the duty.
- R8: The pointer advances by one after each data byte written and after each byte sent to the host, so several registers can be moved in one transaction.
- R9: A STOP releases SDA and returns the target to idle. A START at any point abandons the current byte, and a partially shifted byte is never written.
- R10: After reset, SDA is released, the control byte is 0x80 (fan enabled), the duty is 80 and the measured speed is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock line as seen on the bus |
| sdaIn | input | 1 | I2C data line as seen on the bus |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| tachIn | input | 1 | Fan tachometer pulse input, asynchronous |
| fanPwm | output | 1 | Fan PWM drive |

## Verification
The hardest state to reach from the pins is a multi-byte read. In it, the target must let go of SDA after its eighth bit and then see the host's acknowledge. It must also move on to the next register before driving again. The bench sets the pointer, issues a repeated START, reads two bytes with an acknowledge between them and ends with a NACK. It then checks both values and that SDA is free after the STOP. Saturation of the speed counter is reached by running the tachometer far faster than the window can count.

// File: rtl/fan_i2c_pkg.sv
package fan_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_RX, ST_ACKR, ST_TX, ST_MACK
  } busState_t;

  // strobes from bus control to register datapath, one cycle wide
  typedef struct packed {
    logic       setPtr;
    logic       wrData;
    logic       nextPtr;
    logic [7:0] rxByte;
  } regStrobe_t;

endpackage

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h74
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output regStrobe_t strb,
  output logic       sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       scl, sda, sclRise, sclFall, startDet, stopDet;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, shiftOut;
  logic       isRead, firstByte, masterNack;

  assign scl      = sclSync[1];
  assign sda      = sdaSync[1];
  assign sclRise  = scl & ~sclPrev;
  assign sclFall  = ~scl & sclPrev;
  assign startDet = scl & sclPrev & sdaPrev & ~sda;
  assign stopDet  = scl & sclPrev & ~sdaPrev & sda;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= scl;
      sdaPrev <= sda;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      shiftIn    <= '0;
      shiftOut   <= '0;
      isRead     <= 1'b0;
      firstByte  <= 1'b0;
      masterNack <= 1'b0;
      sdaOe      <= 1'b0;
      strb       <= '0;
    end else begin
      strb.setPtr  <= 1'b0;
      strb.wrData  <= 1'b0;
      strb.nextPtr <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftIn <= {shiftIn[6:0], sda};
              bitCnt  <= bitCnt + 4'd1;
            end
            if (sclFall && bitCnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shiftIn[7:1] == DEV_ADDR) begin
                  sdaOe     <= 1'b1;
                  isRead    <= shiftIn[0];
                  firstByte <= 1'b1;
                  state     <= ST_ACKA;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaOe        <= 1'b1;
                strb.rxByte  <= shiftIn;
                strb.setPtr  <= firstByte;
                strb.wrData  <= ~firstByte;
                firstByte    <= 1'b0;
                state        <= ST_ACKR;
              end
            end
          end
          ST_ACKA: if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              shiftOut <= rdData;
              sdaOe    <= ~rdData[7];
              state    <= ST_TX;
            end else begin
              sdaOe <= 1'b0;
              state <= ST_RX;
            end
          end
          ST_ACKR: if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= ST_RX;
          end
          ST_TX: if (sclFall) begin
            bitCnt <= bitCnt + 4'd1;
            if (bitCnt == 4'd7) begin
              sdaOe        <= 1'b0;
              strb.nextPtr <= 1'b1;
              state        <= ST_MACK;
            end else begin
              shiftOut <= {shiftOut[6:0], 1'b0};
              sdaOe    <= ~shiftOut[6];
            end
          end
          ST_MACK: begin
            if (sclRise) masterNack <= sda;
            if (sclFall) begin
              if (masterNack) begin
                state <= ST_IDLE;
              end else begin
                shiftOut <= rdData;
                sdaOe    <= ~rdData[7];
                bitCnt   <= '0;
                state    <= ST_TX;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);
  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setPtr, strb.wrData, strb.nextPtr}));

endmodule

// File: rtl/fan_datapath.sv
module fan_datapath
  import fan_i2c_pkg::*;
#(
  parameter logic [7:0] CTRL_RESET    = 8'h80,
  parameter logic [7:0] DUTY_RESET    = 8'd80,
  parameter int         PWM_STEPS     = 100,
  parameter int         PWM_DIV       = 8,
  parameter int         WINDOW_CYCLES = 20_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strb,
  input  logic       tachIn,
  output logic [7:0] rdData,
  output logic       fanPwm
);

  localparam int STEP_W = $clog2(PWM_STEPS);
  localparam int DIV_W  = $clog2(PWM_DIV + 1);
  localparam int WIN_W  = $clog2(WINDOW_CYCLES);
  localparam logic [7:0] DUTY_MAX = 8'(PWM_STEPS);

  logic [7:0]  ptr, ctrlReg, dutyReg, rpsReg, edgeCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [STEP_W-1:0] stepCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [2:0]  tachSync;
  logic        tachRise;

  // register file and pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      ctrlReg <= CTRL_RESET;
      dutyReg <= DUTY_RESET;
    end else if (strb.setPtr) begin
      ptr <= strb.rxByte;
    end else if (strb.wrData) begin
      if (ptr == 8'd0) ctrlReg <= strb.rxByte;
      if (ptr == 8'd1) dutyReg <= (strb.rxByte > DUTY_MAX) ? DUTY_MAX : strb.rxByte;
      ptr <= ptr + 8'd1;
    end else if (strb.nextPtr) begin
      ptr <= ptr + 8'd1;
    end
  end

  always_comb begin
    case (ptr)
      8'd0:    rdData = ctrlReg;
      8'd1:    rdData = rpsReg;
      default: rdData = 8'h00;
    endcase
  end

  // PWM generation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      stepCnt <= '0;
      fanPwm  <= 1'b0;
    end else begin
      if (divCnt == DIV_W'(PWM_DIV - 1)) begin
        divCnt  <= '0;
        stepCnt <= (stepCnt == STEP_W'(PWM_STEPS - 1)) ? '0 : stepCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      fanPwm <= ctrlReg[7] && (8'(stepCnt) < dutyReg);
    end
  end

  // tachometer window counter
  assign tachRise = tachSync[1] & ~tachSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tachSync <= '0;
      winCnt   <= '0;
      edgeCnt  <= '0;
      rpsReg   <= '0;
    end else begin
      tachSync <= {tachSync[1:0], tachIn};
      if (winCnt == WIN_W'(WINDOW_CYCLES - 1)) begin
        winCnt  <= '0;
        rpsReg  <= edgeCnt;
        edgeCnt <= {7'd0, tachRise};
      end else begin
        winCnt <= winCnt + 1'b1;
        if (tachRise && edgeCnt != 8'hFF) edgeCnt <= edgeCnt + 8'd1;
      end
    end
  end

  // R5
  duty_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dutyReg <= DUTY_MAX);
  // R3
  pwm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[7] |=> !fanPwm);
  // R6
  rps_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winCnt != '0) |-> $stable(rpsReg));
  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && ptr > 8'd1) |=> ($stable(ctrlReg) && $stable(dutyReg)));

endmodule

// File: rtl/fan_i2c_target.sv
module fan_i2c_target
  import fan_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR      = 7'h74,
  parameter logic [7:0] CTRL_RESET    = 8'h80,
  parameter logic [7:0] DUTY_RESET    = 8'd80,
  parameter int         PWM_STEPS     = 100,
  parameter int         PWM_DIV       = 8,
  parameter int         WINDOW_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic tachIn,
  output logic fanPwm
);

  regStrobe_t strb;
  logic [7:0] rdData;

  i2c_target_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrlU (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strb(strb), .sdaOe(sdaOe)
  );

  fan_datapath #(
    .CTRL_RESET(CTRL_RESET), .DUTY_RESET(DUTY_RESET), .PWM_STEPS(PWM_STEPS),
    .PWM_DIV(PWM_DIV), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) dataU (
    .clk(clk), .rstN(rstN), .strb(strb), .tachIn(tachIn),
    .rdData(rdData), .fanPwm(fanPwm)
  );

endmodule

// File: tb/fan_i2c_target_test.sv
`timescale 1ns/1ps
module fan_i2c_target_test;

  localparam int Q      = 10;
  localparam int WIN    = 2000;
  localparam int PERIOD = 200;   // 100 steps x PWM_DIV 2

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic tachIn = 1'b0;
  logic sdaOe, fanPwm;
  wire  sdaBus = sdaM & ~sdaOe;
  int   tachPer = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  fan_i2c_target #(.PWM_DIV(2), .WINDOW_CYCLES(WIN)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .tachIn(tachIn), .fanPwm(fanPwm)
  );

  always #2.5 clk = ~clk;

  always begin
    if (tachPer == 0) begin
      tachIn = 1'b0;
      @(negedge clk);
    end else begin
      tachIn = 1'b1;
      repeat (tachPer / 2) @(negedge clk);
      tachIn = 1'b0;
      repeat (tachPer - tachPer / 2) @(negedge clk);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sdaM = 1'b1; wait_clk(Q); sclM = 1'b1; wait_clk(Q);
    sdaM = 1'b0; wait_clk(Q); sclM = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sdaM = 1'b0; wait_clk(Q); sclM = 1'b1; wait_clk(Q);
    sdaM = 1'b1; wait_clk(Q);
  endtask

  task automatic bit_out(input logic b);
    sdaM = b; wait_clk(Q); sclM = 1'b1; wait_clk(2 * Q); sclM = 1'b0; wait_clk(Q);
  endtask

  task automatic bit_in(output logic b);
    sdaM = 1'b1; wait_clk(Q); sclM = 1'b1; wait_clk(Q);
    b = sdaBus; wait_clk(Q); sclM = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~ackIt);
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] v);
    logic ak;
    bus_start();
    send_byte(8'hE8, ak); check("R1 address ack", ak, 1);
    send_byte(p, ak);
    send_byte(v, ak);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] v);
    logic ak;
    bus_start();
    send_byte(8'hE8, ak);
    send_byte(p, ak);
    bus_start();
    send_byte(8'hE9, ak); check("R1 read address ack", ak, 1);
    recv_byte(1'b0, v);
    bus_stop();
    check("R9 SDA free after stop", sdaOe, 0);
  endtask

  task automatic pwm_high(output int n);
    n = 0;
    wait_clk(PERIOD + 20);
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (fanPwm) n++;
    end
  endtask

  task automatic test_reset();
    logic [7:0] v; int n;
    check("R10 SDA released at reset", sdaOe, 0);
    pwm_high(n); check("R10 R4 default duty 80", n, 160);
    read_reg(8'd0, v); check("R10 control reset", v, 8'h80);
    read_reg(8'd1, v); check("R10 speed reset", v, 0);
  endtask

  task automatic test_nack();
    logic ak; logic [7:0] v;
    bus_start();
    send_byte(8'hEA, ak); check("R1 foreign address nack", ak, 0);
    send_byte(8'h00, ak); check("R1 byte after nack ignored", ak, 0);
    send_byte(8'h00, ak);
    bus_stop();
    read_reg(8'd0, v); check("R1 control untouched", v, 8'h80);
  endtask

  task automatic test_duty();
    int n;
    write_reg(8'd1, 8'd25);  pwm_high(n); check("R4 duty 25", n, 50);
    write_reg(8'd1, 8'd0);   pwm_high(n); check("R4 duty 0", n, 0);
    write_reg(8'd1, 8'd100); pwm_high(n); check("R4 duty 100", n, PERIOD);
  endtask

  task automatic test_clamp();
    int n;
    write_reg(8'd1, 8'd0);
    write_reg(8'd1, 8'd200); pwm_high(n); check("R5 duty 200 clamps", n, PERIOD);
    write_reg(8'd1, 8'd0);
    write_reg(8'd1, 8'd101); pwm_high(n); check("R5 duty 101 clamps", n, PERIOD);
  endtask

  task automatic test_enable();
    int n; logic [7:0] v;
    write_reg(8'd1, 8'd50);
    write_reg(8'd0, 8'h00); pwm_high(n); check("R3 disabled fan low", n, 0);
    read_reg(8'd0, v); check("R2 control readback 00", v, 8'h00);
    write_reg(8'd0, 8'h8F); pwm_high(n); check("R3 enabled duty 50", n, 100);
    read_reg(8'd0, v); check("R2 control readback 8F", v, 8'h8F);
  endtask

  task automatic test_tach();
    logic [7:0] v;
    tachPer = 40; wait_clk(2 * WIN + 100);
    read_reg(8'd1, v); check("R6 speed 50 per window", v, 50);
    tachPer = 4; wait_clk(2 * WIN + 100);
    read_reg(8'd1, v); check("R6 speed saturates", v, 255);
    tachPer = 0; wait_clk(2 * WIN + 100);
    read_reg(8'd1, v); check("R6 speed back to zero", v, 0);
  endtask

  task automatic test_unmapped();
    logic [7:0] v; int n;
    write_reg(8'd1, 8'd30);
    write_reg(8'd7, 8'h55);
    read_reg(8'd7, v); check("R7 unmapped reads zero", v, 0);
    read_reg(8'd0, v); check("R7 control unchanged", v, 8'h8F);
    pwm_high(n); check("R7 duty unchanged", n, 60);
  endtask

  task automatic test_seq();
    logic ak; logic [7:0] a, b; int n;
    bus_start();
    send_byte(8'hE8, ak);
    send_byte(8'd0, ak);
    send_byte(8'h81, ak); check("R8 first data ack", ak, 1);
    send_byte(8'd60, ak); check("R8 second data ack", ak, 1);
    bus_stop();
    pwm_high(n); check("R8 duty via advanced pointer", n, 120);
    tachPer = 40; wait_clk(2 * WIN + 100);
    bus_start();
    send_byte(8'hE8, ak);
    send_byte(8'd0, ak);
    bus_start();
    send_byte(8'hE9, ak);
    recv_byte(1'b1, a);
    recv_byte(1'b0, b);
    bus_stop();
    check("R8 burst byte 0", a, 8'h81);
    check("R8 burst byte 1", b, 50);
    check("R9 SDA free after burst", sdaOe, 0);
    tachPer = 0;
  endtask

  task automatic test_abort();
    logic ak; logic [7:0] v;
    bus_start();
    send_byte(8'hE8, ak);
    send_byte(8'd0, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_start();
    bus_stop();
    check("R9 SDA free after abort", sdaOe, 0);
    read_reg(8'd0, v); check("R9 partial byte discarded", v, 8'h81);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5);
    rstN = 1'b1;
    wait_clk(5);
    test_reset();
    test_nack();
    test_duty();
    test_clamp();
    test_enable();
    test_tach();
    test_unmapped();
    test_seq();
    test_abort();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule